// File: doc/BRIEF.md
# Burst Read Wait-State Controller

This block is the read-latency engine of a synchronous flash-style memory port. The host first writes a configuration word. It pulses a load strobe, and the latency code and the power-saving flag are taken from two fixed address bit positions. The host then opens a burst by holding the address-valid strobe low with chip enable low across a clock edge. The controller captures the starting word address and counts out the programmed initial latency. After that it presents one word per clock from a memory array that it addresses through its own `mem_addr` output.

The address advances linearly and wraps at the top of the address space. The burst has no length limit. The memory is split into 64-word pages. Whenever the burst leaves the last word of a page, the controller inserts a wait cycle. It inserts a second wait cycle when power saving is on. During these waits the ready output is low and the data output keeps the previous word. A burst that starts on the last word of a page pays one extra cycle of initial latency. Power saving adds one more. Raising chip enable ends the burst at once.

Top module: `burst_wait_ctrl`

## Requirements
- R1: After reset, `rdy` is low, `dout` is 0, the latency code is 00 and power saving is off. A burst started right after reset therefore shows its first word after 4 edges.
- R2: On an edge where `cfg_load` is high, the latency code is taken from `addr_in[13:12]` and the power-saving flag from `addr_in[14]`. The base initial latency is 4 + code edges, so it runs from 4 to 7.
- R3: An edge that samples `ce_n` low, `avd_n` low and `cfg_load` low starts a burst and captures `addr_in`. Counting that edge as edge 0, the first word appears with `rdy` high after edge N, where N is the sum of the base latency and the additions in R4 and R5. An edge with both `cfg_load` and `avd_n` low does not start a burst.
- R4: A starting address whose low six bits are all ones adds 1 to N.
- R5: Power saving enabled adds 1 to N.
- R6: After the first word, each edge presents the next word. The words come from addresses start, start+1, … modulo 2^16, and `dout` equals the array word at each address.
- R7: After a word whose low six address bits are all ones, the next edge gives one cycle with `rdy` low and `dout` held. With power saving on there is a second such cycle. The word from the next page follows.
- R8: `rdy` is low in any cycle where `oe_n` or `ce_n` is high. A high `oe_n` does not pause the burst.
- R9: An edge that samples `ce_n` high ends the burst. `rdy` then stays low until a new burst start.
- R10: `rdy` is high only in cycles that present a new word. `dout` does not change in cycles where `rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable; high ends a burst |
| oe_n | input | 1 | Active-low output enable; gates `rdy` |
| avd_n | input | 1 | Active-low address-valid strobe; starts a burst |
| cfg_load | input | 1 | Loads the latency code and power-saving flag from `addr_in` |
| addr_in | input | 16 | Start word address, or configuration word |
| mem_rdata | input | 16 | Array word at `mem_addr` |
| mem_addr | output | 16 | Address of the next word to present |
| rdy | output | 1 | High when `dout` holds a new valid word |
| dout | output | 16 | Burst data word |

## Verification
A wrong wait counter shows up as the first `rdy` pulse arriving one or more edges early or late. The bench sees this in the first few cycles of the burst. A wrong page-boundary flag or a wrong address increment causes either a missing or extra low `rdy` cycle right after an address ending in 3Fh, or a `dout` value that no longer matches the array. Either fault is visible on the very next edge. The sweep covers every latency code, both power-saving settings, page-straddling start addresses and the wrap from FFFFh to 0000h. These are exactly the cases where such faults would otherwise hide.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    typedef enum logic [1:0] {
        BW_IDLE = 2'd0,
        BW_WAIT = 2'd1,
        BW_DATA = 2'd2
    } bw_state_e;

    localparam int unsigned BW_CNT_W = 4;
    localparam int unsigned BW_CNT_MAX = 9;
endpackage

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code_in,
    input  logic       ps_in,
    output logic [1:0] code_q,
    output logic       ps_q
);
    logic [1:0] code_d;
    logic       ps_d;

    always_comb begin
        code_d = code_q;
        ps_d   = ps_q;
        if (load) begin
            code_d = code_in;
            ps_d   = ps_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= 2'b00;
            ps_q   <= 1'b0;
        end else begin
            code_q <= code_d;
            ps_q   <= ps_d;
        end
    end
endmodule

// File: rtl/bwc_lat_calc.sv
module bwc_lat_calc
    import bwc_pkg::*;
(
    input  logic [1:0]          code,
    input  logic                ps,
    input  logic                at_bnd,
    output logic [BW_CNT_W-1:0] init_cnt,
    output logic [BW_CNT_W-1:0] cross_cnt
);
    // the counter value is (edges to wait) - 1: base 4+code gives 3+code
    always_comb begin
        init_cnt  = BW_CNT_W'(3) + BW_CNT_W'(code) + BW_CNT_W'(ps) + BW_CNT_W'(at_bnd);
        cross_cnt = BW_CNT_W'(ps);
    end
endmodule

// File: rtl/burst_wait_ctrl.sv
module burst_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 16,
    parameter int unsigned BND_BITS = 6,
    parameter int unsigned CODE_LSB = 12,
    parameter int unsigned PS_BIT   = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          avd_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          rdy,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        bw_state_e           st;
        logic [BW_CNT_W-1:0] cnt;
        logic [AW-1:0]       nxt;
        logic                last;
        logic                rdy;
        logic [DW-1:0]       dout;
    } bw_regs_t;

    bw_regs_t s_d, s_q;

    logic [1:0]          code_q;
    logic                ps_q;
    logic                at_bnd;
    logic [BW_CNT_W-1:0] init_cnt;
    logic [BW_CNT_W-1:0] cross_cnt;
    logic                present;

    bwc_cfg_reg cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .code_in (addr_in[CODE_LSB+1:CODE_LSB]),
        .ps_in   (addr_in[PS_BIT]),
        .code_q  (code_q),
        .ps_q    (ps_q)
    );

    assign at_bnd = &addr_in[BND_BITS-1:0];

    bwc_lat_calc lat_i (
        .code      (code_q),
        .ps        (ps_q),
        .at_bnd    (at_bnd),
        .init_cnt  (init_cnt),
        .cross_cnt (cross_cnt)
    );

    always_comb begin
        s_d     = s_q;
        present = 1'b0;
        if (ce_n) begin
            s_d.st  = BW_IDLE;
            s_d.rdy = 1'b0;
        end else if (!avd_n && !cfg_load) begin
            s_d.st   = BW_WAIT;
            s_d.cnt  = init_cnt;
            s_d.nxt  = addr_in;
            s_d.last = 1'b0;
            s_d.rdy  = 1'b0;
        end else begin
            case (s_q.st)
                BW_WAIT: begin
                    if (s_q.cnt == '0) begin
                        present = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - BW_CNT_W'(1);
                        s_d.rdy = 1'b0;
                    end
                end
                BW_DATA: begin
                    if (s_q.last) begin
                        s_d.st  = BW_WAIT;
                        s_d.cnt = cross_cnt;
                        s_d.rdy = 1'b0;
                    end else begin
                        present = 1'b1;
                    end
                end
                default: s_d.rdy = 1'b0;
            endcase
        end
        if (present) begin
            s_d.st   = BW_DATA;
            s_d.dout = mem_rdata;
            s_d.rdy  = 1'b1;
            s_d.last = &s_q.nxt[BND_BITS-1:0];
            s_d.nxt  = s_q.nxt + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: BW_IDLE, cnt: '0, nxt: '0, last: 1'b0, rdy: 1'b0, dout: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr = s_q.nxt;
    assign dout     = s_q.dout;
    assign rdy      = s_q.rdy & ~oe_n & ~ce_n;

    // R9: chip enable high ends the burst
    a_r9_ce_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !s_q.rdy);

    // R10: data never moves while ready is low
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.rdy |-> $stable(s_q.dout));

    // R3: a start never yields a word on the next edge
    a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !avd_n && !cfg_load) |=> (!s_q.rdy && s_q.st == BW_WAIT));

    // R7: leaving a page always costs a wait cycle
    a_r7_cross_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && avd_n && !cfg_load && s_q.rdy && s_q.last) |=> !s_q.rdy);

    // R6: inside a page, words stream back to back with a stepping address
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && avd_n && !cfg_load && s_q.rdy && !s_q.last)
        |=> (s_q.rdy && mem_addr == $past(mem_addr) + AW'(1)));

    // R4: the wait counter stays within the largest latency
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= BW_CNT_W'(BW_CNT_MAX));
endmodule

// File: tb/burst_wait_ctrl_tb.sv
module burst_wait_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] KEY = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        avd_n = 1'b1;
    logic        cfg_load = 1'b0;
    logic [15:0] addr_in = '0;
    logic [15:0] mem_rdata;
    logic [15:0] mem_addr;
    logic        rdy;
    logic [15:0] dout;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] exp_dout = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural array: word = address xor key
    assign mem_rdata = mem_addr ^ KEY;

    burst_wait_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .avd_n(avd_n),
        .cfg_load(cfg_load), .addr_in(addr_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .rdy(rdy), .dout(dout)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic load_cfg(input int code, input int ps);
        @(negedge clk);
        ce_n = 1'b1; avd_n = 1'b1; cfg_load = 1'b1;
        addr_in = 16'((ps << 14) | (code << 12));
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // gap_k: cycle with oe_n high (R8); stop_k: cycle after which ce_n pulses high (R9)
    task automatic run(input int code, input int ps, input logic [15:0] start,
                       input int nwords, input int gap_k, input int stop_k);
        int pend;
        int got;
        logic [15:0] a;
        string ftag;
        ftag = (start[5:0] == 6'h3F) ? "R4" : (ps != 0) ? "R5" : (code != 0) ? "R2" : "R3";
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; avd_n = 1'b0; addr_in = start;
        @(negedge clk);
        avd_n = 1'b1;
        #1;
        chk(rdy == 1'b0, "R3 start edge rdy", int'(rdy), 0);
        pend = 4 + code + ps + ((start[5:0] == 6'h3F) ? 1 : 0);
        got = 0;
        a = start;
        for (int k = 1; got < nwords && k < 200; k++) begin
            logic er;
            @(negedge clk);
            oe_n = (k == gap_k);
            #1;
            pend--;
            er = 1'b0;
            if (pend == 0) begin
                er = 1'b1;
                exp_dout = a ^ KEY;
                pend = (a[5:0] == 6'h3F) ? 2 + ps : 1;
                a = a + 16'd1;
                got++;
            end
            if (k == gap_k) begin
                chk(rdy == 1'b0, "R8 oe_n high gates rdy", int'(rdy), 0);
            end else if (got == 1 && er) begin
                chk(rdy == 1'b1, {ftag, " first word latency"}, int'(rdy), 1);
            end else begin
                chk(rdy == er, er ? "R6 streaming rdy" : "R7 wait/hold rdy", int'(rdy), int'(er));
            end
            chk(dout == exp_dout, er ? "R6 word data" : "R10 held data", int'(dout), int'(exp_dout));
            if (k == stop_k) begin
                ce_n = 1'b1;
                @(negedge clk);
                ce_n = 1'b0;
                for (int j = 0; j < 10; j++) begin
                    @(negedge clk);
                    #1;
                    chk(rdy == 1'b0, "R9 burst ended", int'(rdy), 0);
                end
                got = nwords;
            end
        end
        oe_n = 1'b1;
        ce_n = 1'b1;
        @(negedge clk);
        #1;
        chk(rdy == 1'b0, "R8 ce_n high rdy", int'(rdy), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] starts [4];
        starts[0] = 16'h0000; starts[1] = 16'h003C;
        starts[2] = 16'h007F; starts[3] = 16'hFFFD;
        repeat (3) @(negedge clk);
        #1;
        chk(rdy == 1'b0, "R1 reset rdy", int'(rdy), 0);
        chk(dout == 16'h0000, "R1 reset dout", int'(dout), 0);
        rst_n = 1'b1;
        // R1: default config gives 4-cycle latency without any load
        run(0, 0, 16'h0010, 4, 0, 0);
        for (int c = 0; c < 4; c++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 4; s++) begin
                    load_cfg(c, p);
                    run(c, p, starts[s], 9, 0, 0);
                end
        // R2: cfg_load together with avd_n low does not start a burst
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; avd_n = 1'b0; cfg_load = 1'b1; addr_in = 16'h0000;
        @(negedge clk);
        avd_n = 1'b1; cfg_load = 1'b0;
        repeat (8) begin
            @(negedge clk);
            #1;
            chk(rdy == 1'b0, "R2 load blocks start", int'(rdy), 0);
        end
        ce_n = 1'b1;
        // R8: oe_n pulse mid-burst
        load_cfg(1, 0);
        run(1, 0, 16'h0020, 6, 7, 0);
        // R9: ce_n pulse ends burst
        load_cfg(2, 1);
        run(2, 1, 16'h0100, 20, 9, 10);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule